// File: doc/BRIEF.md
# SDRAM Burst Write Sequencer with Automatic Precharge

This block drives the command, address and data pins of a two-bank, 16-bit single-data-rate SDRAM for one kind of transaction. That transaction is a burst write that closes its row by itself when the burst ends. A requester offers a bank, a row, a column, a burst-length code and a stream of write data. When the request is accepted, the sequencer opens the row if the bank is closed. After the row-to-column delay it issues the combined write-and-precharge command. It then streams one data word per clock, starting in the same clock as the command.

After the last data word the sequencer holds the command bus at no-operation. It waits out the write-recovery time and the precharge time, then reports the bank closed and accepts new work. A full-page burst is different. It moves one word for every column, and the device ignores the precharge request, so the sequencer waits only for write recovery and leaves the bank marked open. A later request to an open bank goes straight to the write command on the row that is already open.

Top module: `sdram_wap_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pins show no-operation ({ras_n,cas_n,we_n}=111), `req_ready`=1, `sd_dq_oe`=0 and both `bank_open` bits are 0.
- R2: A request accepted for a closed bank gives an Activate ({ras_n,cas_n,we_n}=011) in the next cycle, with the bank on address bit 11 and the row on bits 10..0. The bank's `bank_open` bit is 1 from the cycle after the Activate.
- R3: The write-with-precharge command ({ras_n,cas_n,we_n}=100) comes exactly T_RCD cycles after the Activate. Address bit 11 holds the bank, bit 10 is 1, bits 7..0 hold the column and bits 9..8 are 0.
- R4: `sd_dq_oe` and `data_take` are 1 for exactly the burst's beat count of consecutive cycles, starting with the write-command cycle. In each of those cycles `sd_dq` equals `wr_data`.
- R5: The burst code `req_burst` is captured at acceptance. Codes 0,1,2,3 give 1,2,4,8 beats, code 7 gives a full page of 2**COL_W beats, and codes 4..6 behave as code 0.
- R6: Every cycle that carries neither Activate nor write carries no-operation (111).
- R7: For a burst of fewer than a full page with last beat in cycle L, no command appears and `req_ready` stays 0 up to cycle L+T_WR+T_RP. In that cycle `req_ready` returns to 1 and the bank's `bank_open` bit reads 0.
- R8: For a full-page burst, `req_ready` returns to 1 in cycle L+T_WR, and the bank's `bank_open` bit stays 1.
- R9: A request accepted for an open bank skips the Activate. Its write command appears in the cycle after acceptance, and `req_row` is ignored.
- R10: From acceptance until `req_ready` returns, `req_valid` has no effect: no command is issued beyond the accepted transaction's own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request accepted when both are 1 |
| req_bank | input | 1 | Target bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Start column |
| req_burst | input | 3 | Burst-length code |
| wr_data | input | DQ_W | Write data for the current beat |
| data_take | output | 1 | Current beat consumes `wr_data` |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W+1 | Address bus; top bit selects the bank |
| sd_dq | output | DQ_W | Write data bus |
| sd_dq_oe | output | 1 | Data bus output enable |
| bank_open | output | 2 | Per-bank open-row flag |

## Verification
A wrong state or counter value in this block shows up at the pins within a few cycles. The gap between Activate and write shifts, the number of enabled data beats changes, or `req_ready` returns a cycle early or late. A stale open-bank flag shows up on the next request to that bank: an Activate is missing or an extra one appears in the cycle after acceptance. The bench models every cycle of each transaction from the parameters and compares all pins in each cycle. It sweeps every burst code on both banks, starting from both closed and open banks.

// File: rtl/sdram_wap_pkg.sv
`timescale 1ns/1ps
package sdram_wap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_WR, ST_BURST, ST_LOCK
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP, CMD_ACT, CMD_WRAP
  } sd_cmd_e;

  localparam logic [2:0] BURST_FULL_CODE = 3'd7;
endpackage

// File: rtl/sdram_wap_burst_len.sv
`timescale 1ns/1ps
module sdram_wap_burst_len #(
  parameter int COL_W = 8,
  parameter int CNT_W = 9
) (
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] beats_m1_o,
  output logic             full_o
);
  import sdram_wap_pkg::*;

  localparam int PAGE_BEATS = 1 << COL_W;

  always_comb begin
    full_o = (code_i == BURST_FULL_CODE);
    if (full_o) begin
      beats_m1_o = CNT_W'(PAGE_BEATS - 1);
    end else if (code_i[2] == 1'b0) begin
      beats_m1_o = CNT_W'((32'd1 << code_i[1:0]) - 32'd1);
    end else begin
      beats_m1_o = '0;
    end
  end
endmodule

// File: rtl/sdram_wap_cmd_enc.sv
`timescale 1ns/1ps
module sdram_wap_cmd_enc #(
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  sdram_wap_pkg::sd_cmd_e cmd_i,
  input  logic                   bank_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [COL_W-1:0]       col_i,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic [ROW_W:0]         addr_o
);
  import sdram_wap_pkg::*;

  localparam int AP_BIT = ROW_W - 1;

  always_comb begin
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    addr_o  = '0;
    unique case (cmd_i)
      CMD_ACT: begin
        ras_n_o = 1'b0;
        addr_o  = {bank_i, row_i};
      end
      CMD_WRAP: begin
        cas_n_o = 1'b0;
        we_n_o  = 1'b0;
        addr_o[ROW_W]       = bank_i;
        addr_o[AP_BIT]      = 1'b1;
        addr_o[COL_W-1:0]   = col_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_wap_bank_track.sv
`timescale 1ns/1ps
module sdram_wap_bank_track #(
  parameter int NBANK = 2,
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NBANK-1:0] open_o
);
  logic [NBANK-1:0] open_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit, en, nxt;
    assign hit = (sel_i == SEL_W'(b));
    assign en  = hit && (set_i || clr_i);
    assign nxt = set_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
      end else if (en) begin
        open_q[b] <= nxt;
      end
    end
  end

  assign open_o = open_q;

  // R2
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> !clr_i);
endmodule

// File: rtl/sdram_wap_seq.sv
`timescale 1ns/1ps
module sdram_wap_seq #(
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  parameter int DQ_W  = 16,
  parameter int T_RCD = 2,
  parameter int T_WR  = 2,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [2:0]       req_burst,
  input  logic [DQ_W-1:0]  wr_data,
  output logic             data_take,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [ROW_W:0]   sd_addr,
  output logic [DQ_W-1:0]  sd_dq,
  output logic             sd_dq_oe,
  output logic [1:0]       bank_open
);
  import sdram_wap_pkg::*;

  localparam int NBANK  = 2;
  localparam int AP_BIT = ROW_W - 1;
  localparam int PAGE   = 1 << COL_W;
  localparam int MAX_A  = (PAGE > T_RCD) ? PAGE : T_RCD;
  localparam int MAX_V  = (MAX_A > T_WR + T_RP) ? MAX_A : T_WR + T_RP;
  localparam int CNT_W  = $clog2(MAX_V + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] bm1_q;
  logic             full_q;

  logic [CNT_W-1:0] bm1_dec;
  logic             full_dec;
  logic             accept, beat, last_beat, to_idle;
  logic [CNT_W-1:0] lock_len;
  sd_cmd_e          cmd;

  sdram_wap_burst_len #(.COL_W(COL_W), .CNT_W(CNT_W)) u_blen (
    .code_i     (req_burst),
    .beats_m1_o (bm1_dec),
    .full_o     (full_dec)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat      = (state_q == ST_WR) || (state_q == ST_BURST);
  assign last_beat = (state_q == ST_WR) ? (bm1_q == '0)
                   : ((state_q == ST_BURST) && (cnt_q == '0));
  assign lock_len  = full_q ? CNT_W'(T_WR - 1) : CNT_W'(T_WR + T_RP - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    to_idle = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = bank_open[req_bank] ? ST_WR : ST_ACT;
        end
      end
      ST_ACT: begin
        if (T_RCD > 1) begin
          state_d = ST_RCD;
          cnt_d   = CNT_W'((T_RCD > 1) ? T_RCD - 2 : 0);
        end else begin
          state_d = ST_WR;
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) state_d = ST_WR;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WR, ST_BURST: begin
        if (last_beat) begin
          if (lock_len == '0) begin
            state_d = ST_IDLE;
            to_idle = 1'b1;
          end else begin
            state_d = ST_LOCK;
            cnt_d   = lock_len - 1'b1;
          end
        end else if (state_q == ST_WR) begin
          state_d = ST_BURST;
          cnt_d   = bm1_q - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_LOCK: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          to_idle = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      bm1_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      bm1_q  <= bm1_dec;
      full_q <= full_dec;
    end
  end

  sdram_wap_bank_track #(.NBANK(NBANK)) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (state_q == ST_ACT),
    .clr_i  (to_idle && !full_q),
    .sel_i  (bank_q),
    .open_o (bank_open)
  );

  always_comb begin
    cmd = CMD_NOP;
    if (state_q == ST_ACT)     cmd = CMD_ACT;
    else if (state_q == ST_WR) cmd = CMD_WRAP;
  end

  sdram_wap_cmd_enc #(.ROW_W(ROW_W), .COL_W(COL_W)) u_enc (
    .cmd_i   (cmd),
    .bank_i  (bank_q),
    .row_i   (row_q),
    .col_i   (col_q),
    .ras_n_o (sd_ras_n),
    .cas_n_o (sd_cas_n),
    .we_n_o  (sd_we_n),
    .addr_o  (sd_addr)
  );

  assign data_take = beat;
  assign sd_dq_oe  = beat;
  assign sd_dq     = beat ? wr_data : '0;

  // R6
  act_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_ras_n |-> (sd_cas_n && sd_we_n));

  // R3
  wr_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cas_n |-> (!sd_we_n && sd_ras_n && sd_addr[AP_BIT] && sd_dq_oe));

  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && (T_RCD > 1)) |=> sd_cas_n);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n || !sd_cas_n) |-> !req_ready);

  // R7
  ready_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (sd_ras_n && sd_cas_n && !sd_dq_oe));
endmodule

// File: tb/sdram_wap_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_wap_seq_tb_top;
  localparam int ROW_W = 11;
  localparam int COL_W = 8;
  localparam int DQ_W  = 16;
  localparam int T_RCD = 2;
  localparam int T_WR  = 2;
  localparam int T_RP  = 2;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [2:0]       req_burst;
  logic [DQ_W-1:0]  wr_data;
  logic             data_take;
  logic             sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W:0]   sd_addr;
  logic [DQ_W-1:0]  sd_dq;
  logic             sd_dq_oe;
  logic [1:0]       bank_open;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  int  reqn   = 0;
  bit  model_open [2];

  sdram_wap_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_burst(req_burst), .wr_data(wr_data), .data_take(data_take),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe),
    .bank_open(bank_open)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int beats_of(input int code);
    if (code == 7) return 1 << COL_W;
    if (code < 4)  return 1 << code;
    return 1;
  endfunction

  task automatic do_req(input bit b, input int code);
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    int n, kact, kw, klast, kend;
    bit was_open, full;
    row  = ROW_W'(11'h5A3 ^ (code * 37 + b * 101 + reqn * 13));
    col  = COL_W'(code * 29 + b * 7 + reqn + 3);
    n    = beats_of(code);
    full = (code == 7);
    was_open = model_open[b];
    kact  = was_open ? 0 : 1;
    kw    = was_open ? 1 : 1 + T_RCD;
    klast = kw + n - 1;
    kend  = klast + T_WR + (full ? 0 : T_RP);
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_bank  = b;
    req_row   = row;
    req_col   = col;
    req_burst = 3'(code);
    for (int k = 1; k <= kend; k++) begin
      bit bt;
      logic [2:0] pins;
      @(negedge clk);
      bt = (k >= kw) && (k <= klast);
      wr_data = DQ_W'(16'hA000 ^ (reqn << 8) ^ (k - kw));
      #1;
      pins = {sd_ras_n, sd_cas_n, sd_we_n};
      if (k == kact) begin
        // R2 activate with bank and row
        chk(pins == 3'b011, "R2 activate pins", pins, 3'b011);
        chk(sd_addr == {b, row}, "R2 activate address", sd_addr, {b, row});
      end else if (k == kw) begin
        // R3 / R9 write with auto precharge
        chk(pins == 3'b100, was_open ? "R9 write pins" : "R3 write pins", pins, 3'b100);
        chk(sd_addr == {b, 1'b1, 2'b00, col}, "R3 write address",
            sd_addr, {b, 1'b1, 2'b00, col});
        chk(bank_open[b] == 1'b1, "R2 bank open at write", bank_open[b], 1);
      end else begin
        // R6 / R10 no-operation elsewhere
        chk(pins == 3'b111, "R6 R10 nop pins", pins, 3'b111);
      end
      // R4 / R5 beat window and data
      chk(sd_dq_oe == bt && data_take == bt, "R4 R5 beat window",
          {sd_dq_oe, data_take}, {bt, bt});
      if (bt) chk(sd_dq == wr_data, "R4 data", sd_dq, wr_data);
      // R7 / R8 ready timing
      chk(req_ready == (k == kend), full ? "R8 ready timing" : "R7 ready timing",
          req_ready, (k == kend));
      if (k == kend) begin
        model_open[b] = full;
        chk(bank_open[b] == full, full ? "R8 bank stays open" : "R7 bank closed",
            bank_open[b], full);
        req_valid = 1'b0;
      end else begin
        // R10 junk request while busy
        req_valid = 1'b1;
        req_bank  = ~b;
        req_row   = ROW_W'(k * 3);
        req_col   = COL_W'(k * 5);
        req_burst = 3'(k);
      end
    end
    reqn++;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_bank = 1'b0; req_row = '0; req_col = '0;
    req_burst = '0; wr_data = '0;
    model_open[0] = 0; model_open[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 nop in reset",
        {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(sd_dq_oe == 1'b0, "R1 dq disabled", sd_dq_oe, 0);
    chk(bank_open == 2'b00, "R1 banks closed", bank_open, 0);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 nop",
        {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    // closed banks, every code (R5, R7, R8)
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 2; b++)
        do_req(b[0], c);
    // both banks now open: R9 skip activate, then close
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 2; b++) begin
        if (!model_open[b]) do_req(b[0], 7);
        do_req(b[0], c);
      end
    // idle gap then more traffic from closed banks
    repeat (5) @(negedge clk);
    chk(bank_open == 2'b00, "R7 banks closed after sweep", bank_open, 0);
    do_req(1'b1, 3);
    do_req(1'b0, 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule